// File: doc/BRIEF.md
# Miss Tracking Entry

One tracking slot for a non-blocking cache. When a request misses, the slot is opened with the line address, the access size, an uncacheable mark, a ready time and an order number. The request that caused the miss is kept as its first waiting target. Each later request to the same line is stored as one more target. Targets go into one of two bounded queues. The active queue is answered by the fetch already in flight. The deferred queue holds requests that need a second fetch, because the fetch now outstanding cannot satisfy them.

The slot also takes snoops from the memory side while its fetch is outstanding. If the slot is waiting for an owned (exclusive) copy, a snoop makes it promise to answer later: the slot pulses a memory-inhibit output and stores the snoop as a target. If the slot is waiting for a shared copy and the snoop asks for ownership, the slot marks its pending copy as invalidated and stores the snoop. Every other snoop is dropped.

When the active queue has been drained, a promote command turns the deferred queue into the active one. A dealloc command then frees the slot once both queues are empty. Exactly one command is applied on each clock. All outputs are registered and show the result one cycle after the command is sampled.

Top module: `miss_track_entry`

## Requirements
- R1: Command ALLOC (code 1) opens the slot. It stores the address, size, uncacheable mark, ready time (req_stamp_i) and order number (req_seq_i). It clears in-service, pending-invalidate and deferred-exclusive, and sets needs-exclusive to req_excl_i. Both queues are emptied, the request becomes the only active target with its cpu flag at 1, and the target count becomes 1.
- R2: Command CPU_ADD (code 2) while not in service always appends the target to the active queue. If req_excl_i is 1, it sets needs-exclusive.
- R3: Command CPU_ADD while in service places the target in the deferred queue if any of these is true: the deferred queue is non-empty, pending-invalidate is set, or needs-exclusive is clear while req_excl_i is 1. Otherwise the target goes to the active queue and the flags are left unchanged.
- R4: A CPU_ADD that is routed to the deferred queue with req_excl_i at 1 sets deferred-exclusive.
- R5: Command SNOOP (code 3) has no effect when the slot is not in service or when pending-invalidate is already set. In that case no target is stored, no flag changes and inhibit_o stays low.
- R6: A SNOOP while in service with needs-exclusive set gives a one-cycle inhibit_o pulse and stores the snoop in the active queue with its cpu flag at 0.
- R7: A SNOOP while in service with needs-exclusive clear and req_excl_i at 1 sets pending-invalidate and stores the snoop. A SNOOP with needs-exclusive clear and req_excl_i at 0 is dropped.
- R8: Command PROMOTE (code 6) acts only when the deferred queue is non-empty and the active queue is empty. It moves the deferred targets, in their original order, into the active queue. It loads needs-exclusive from deferred-exclusive, clears pending-invalidate and deferred-exclusive, and pulses promoted_o for one cycle. In every other case it changes nothing and promoted_o stays low.
- R9: A successful PROMOTE sets the order number to the first promoted target's order number. It sets the ready time to whichever is later: now_i or that target's timestamp.
- R10: The target count rises by one for every stored target, whether active, deferred or snoop, and falls by one for every POP (code 5) of a non-empty active queue. A POP of an empty active queue changes nothing. DEALLOC (code 7) clears valid and in-service only when both queues are empty and the count is zero. SERVICE (code 4) sets in-service.
- R11: A target routed to a full queue is not stored and the count does not change. overflow_o pulses for one cycle, and the routing flags still update as R2 to R7 describe.
- R12: While the slot is not valid, every command other than ALLOC leaves all state unchanged. Reset clears valid, in-service, the flags, both queues and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command: 0 idle, 1 alloc, 2 cpu add, 3 snoop, 4 service, 5 pop, 6 promote, 7 dealloc |
| req_addr_i | input | 32 | Line address for alloc |
| req_size_i | input | 7 | Access size for alloc |
| req_uncache_i | input | 1 | Uncacheable mark for alloc |
| req_excl_i | input | 1 | Request needs exclusive ownership |
| req_tag_i | input | 8 | Requester tag stored with the target |
| req_stamp_i | input | 16 | Target timestamp (ready time on alloc) |
| req_seq_i | input | 8 | Target order number |
| now_i | input | 16 | Free-running current time |
| valid_o | output | 1 | Slot is open |
| in_service_o | output | 1 | Fetch has been issued |
| line_addr_o | output | 32 | Stored line address |
| line_size_o | output | 7 | Stored size |
| uncache_o | output | 1 | Stored uncacheable mark |
| ready_time_o | output | 16 | Time at which the slot may issue |
| seq_o | output | 8 | Slot order number |
| needs_excl_o | output | 1 | Outstanding fetch asks for ownership |
| pend_inval_o | output | 1 | Pending copy will be invalidated |
| def_excl_o | output | 1 | A deferred target needs ownership |
| ntargets_o | output | 4 | Stored target count |
| act_empty_o | output | 1 | Active queue empty |
| act_full_o | output | 1 | Active queue full |
| def_empty_o | output | 1 | Deferred queue empty |
| def_full_o | output | 1 | Deferred queue full |
| head_tag_o | output | 8 | Active head tag |
| head_stamp_o | output | 16 | Active head timestamp |
| head_seq_o | output | 8 | Active head order number |
| head_cpu_o | output | 1 | Active head came from the CPU side |
| inhibit_o | output | 1 | One-cycle memory-inhibit pulse for a snoop |
| promoted_o | output | 1 | One-cycle pulse on a successful promote |
| overflow_o | output | 1 | One-cycle pulse when a target was refused |

## Verification
The checker assumes that cmd_i carries one defined code per cycle. It also assumes that the queue depth is at least one, so a queue is never full and empty at once. No other limit applies to the inputs: the design defines illegal uses such as a snoop out of service, a promote with a busy active queue, an early dealloc or a command to a closed slot as no-ops. The stimulus therefore draws commands freely from $urandom, and holds back ALLOC while the slot is open only so that long target sequences can build up. Directed runs then fill both queues to overflow and walk the snoop and promote paths in order.

// File: rtl/mte_pkg.sv
package mte_pkg;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 7;
  localparam int TAG_W  = 8;
  localparam int TIME_W = 16;
  localparam int ORD_W  = 8;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_ALLOC   = 3'd1,
    CMD_CPU_ADD = 3'd2,
    CMD_SNOOP   = 3'd3,
    CMD_SERVICE = 3'd4,
    CMD_POP     = 3'd5,
    CMD_PROMOTE = 3'd6,
    CMD_DEALLOC = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [TIME_W-1:0] stamp;
    logic [ORD_W-1:0]  seq;
    logic              cpu_side;
  } tgt_t;

  // a CPU request after issue must wait for a second fetch
  function automatic logic route_to_deferred(input logic in_svc, input logic def_empty,
                                             input logic pend_inval, input logic needs_excl,
                                             input logic req_excl);
    return in_svc && (!def_empty || pend_inval || (!needs_excl && req_excl));
  endfunction

  function automatic logic [TIME_W-1:0] later_time(input logic [TIME_W-1:0] a,
                                                   input logic [TIME_W-1:0] b);
    return (a >= b) ? a : b;
  endfunction
endpackage

// File: rtl/mte_tgt_fifo.sv
module mte_tgt_fifo
  import mte_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush_i,
  input  logic push_i,
  input  logic pop_i,
  input  tgt_t din_i,
  output tgt_t head_o,
  output logic empty_o,
  output logic full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  tgt_t           mem [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  fill;
  logic           do_push, do_pop;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (fill == '0);
  assign full_o  = (fill == CW'(DEPTH));
  assign head_o  = mem[rd_ptr];
  assign do_push = push_i && (flush_i || !full_o);
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush_i) begin
      rd_ptr <= '0;
      wr_ptr <= push_i ? step_ptr('0) : '0;
      fill   <= push_i ? CW'(1) : '0;
    end else begin
      if (do_push) wr_ptr <= step_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[flush_i ? '0 : wr_ptr] <= din_i;
  end
endmodule

// File: rtl/mte_router.sv
module mte_router
  import mte_pkg::*;
(
  input  logic in_svc_i,
  input  logic def_empty_i,
  input  logic pend_inval_i,
  input  logic needs_excl_i,
  input  logic req_excl_i,
  output logic cpu_to_def_o,
  output logic snp_record_o,
  output logic snp_inhibit_o,
  output logic snp_inval_o
);
  logic snp_live;

  assign cpu_to_def_o  = route_to_deferred(in_svc_i, def_empty_i, pend_inval_i,
                                           needs_excl_i, req_excl_i);
  assign snp_live      = in_svc_i && !pend_inval_i;
  assign snp_inhibit_o = snp_live && needs_excl_i;
  assign snp_inval_o   = snp_live && !needs_excl_i && req_excl_i;
  assign snp_record_o  = snp_inhibit_o || snp_inval_o;
endmodule

// File: rtl/miss_track_entry.sv
module miss_track_entry
  import mte_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [2:0]                     cmd_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [SIZE_W-1:0]              req_size_i,
  input  logic                           req_uncache_i,
  input  logic                           req_excl_i,
  input  logic [TAG_W-1:0]               req_tag_i,
  input  logic [TIME_W-1:0]              req_stamp_i,
  input  logic [ORD_W-1:0]               req_seq_i,
  input  logic [TIME_W-1:0]              now_i,
  output logic                           valid_o,
  output logic                           in_service_o,
  output logic [ADDR_W-1:0]              line_addr_o,
  output logic [SIZE_W-1:0]              line_size_o,
  output logic                           uncache_o,
  output logic [TIME_W-1:0]              ready_time_o,
  output logic [ORD_W-1:0]               seq_o,
  output logic                           needs_excl_o,
  output logic                           pend_inval_o,
  output logic                           def_excl_o,
  output logic [$clog2(2*DEPTH+1)-1:0]   ntargets_o,
  output logic                           act_empty_o,
  output logic                           act_full_o,
  output logic                           def_empty_o,
  output logic                           def_full_o,
  output logic [TAG_W-1:0]               head_tag_o,
  output logic [TIME_W-1:0]              head_stamp_o,
  output logic [ORD_W-1:0]               head_seq_o,
  output logic                           head_cpu_o,
  output logic                           inhibit_o,
  output logic                           promoted_o,
  output logic                           overflow_o
);
  localparam int CW = $clog2(2*DEPTH + 1);

  cmd_e cmd;
  logic act_sel;
  tgt_t new_tgt, act_head, def_head;
  tgt_t f_head [2];
  logic [1:0] f_push, f_pop, f_empty, f_full;

  // named internal events
  logic ev_alloc, ev_cpu, ev_snoop, ev_service, ev_pop, ev_promote, ev_dealloc;
  logic cpu_to_def, snp_record, snp_inhibit, snp_inval;
  logic push_act, push_def, store_act, store_def, refused;

  assign cmd = cmd_e'(cmd_i);

  mte_router u_router (
    .in_svc_i      (in_service_o),
    .def_empty_i   (def_empty_o),
    .pend_inval_i  (pend_inval_o),
    .needs_excl_i  (needs_excl_o),
    .req_excl_i    (req_excl_i),
    .cpu_to_def_o  (cpu_to_def),
    .snp_record_o  (snp_record),
    .snp_inhibit_o (snp_inhibit),
    .snp_inval_o   (snp_inval)
  );

  assign act_empty_o = f_empty[act_sel];
  assign act_full_o  = f_full[act_sel];
  assign def_empty_o = f_empty[~act_sel];
  assign def_full_o  = f_full[~act_sel];
  assign act_head    = f_head[act_sel];
  assign def_head    = f_head[~act_sel];

  assign ev_alloc   = (cmd == CMD_ALLOC);
  assign ev_cpu     = valid_o && (cmd == CMD_CPU_ADD);
  assign ev_snoop   = valid_o && (cmd == CMD_SNOOP);
  assign ev_service = valid_o && (cmd == CMD_SERVICE);
  assign ev_pop     = valid_o && (cmd == CMD_POP) && !act_empty_o;
  assign ev_promote = valid_o && (cmd == CMD_PROMOTE) && !def_empty_o && act_empty_o;
  assign ev_dealloc = valid_o && (cmd == CMD_DEALLOC) && act_empty_o && def_empty_o
                      && (ntargets_o == '0);

  assign push_act  = ev_alloc || (ev_cpu && !cpu_to_def) || (ev_snoop && snp_record);
  assign push_def  = ev_cpu && cpu_to_def;
  assign store_act = push_act && (ev_alloc || !act_full_o);
  assign store_def = push_def && !def_full_o;
  assign refused   = (push_act && !ev_alloc && act_full_o) || (push_def && def_full_o);

  assign new_tgt = '{tag: req_tag_i, stamp: req_stamp_i, seq: req_seq_i,
                     cpu_side: !ev_snoop};

  for (genvar gi = 0; gi < 2; gi++) begin : g_q
    assign f_push[gi] = (act_sel == gi[0]) ? store_act : store_def;
    assign f_pop[gi]  = (act_sel == gi[0]) && ev_pop;
    mte_tgt_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (ev_alloc),
      .push_i  (f_push[gi]),
      .pop_i   (f_pop[gi]),
      .din_i   (new_tgt),
      .head_o  (f_head[gi]),
      .empty_o (f_empty[gi]),
      .full_o  (f_full[gi])
    );
  end

  assign head_tag_o   = act_head.tag;
  assign head_stamp_o = act_head.stamp;
  assign head_seq_o   = act_head.seq;
  assign head_cpu_o   = act_head.cpu_side;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o      <= 1'b0;
      in_service_o <= 1'b0;
      line_addr_o  <= '0;
      line_size_o  <= '0;
      uncache_o    <= 1'b0;
      ready_time_o <= '0;
      seq_o        <= '0;
      needs_excl_o <= 1'b0;
      pend_inval_o <= 1'b0;
      def_excl_o   <= 1'b0;
      ntargets_o   <= '0;
      act_sel      <= 1'b0;
      inhibit_o    <= 1'b0;
      promoted_o   <= 1'b0;
      overflow_o   <= 1'b0;
    end else begin
      inhibit_o  <= ev_snoop && snp_inhibit;
      promoted_o <= ev_promote;
      overflow_o <= refused;
      if (ev_alloc) begin
        valid_o      <= 1'b1;
        in_service_o <= 1'b0;
        line_addr_o  <= req_addr_i;
        line_size_o  <= req_size_i;
        uncache_o    <= req_uncache_i;
        ready_time_o <= req_stamp_i;
        seq_o        <= req_seq_i;
        needs_excl_o <= req_excl_i;
        pend_inval_o <= 1'b0;
        def_excl_o   <= 1'b0;
        ntargets_o   <= CW'(1);
      end else begin
        ntargets_o <= ntargets_o + CW'(store_act) + CW'(store_def) - CW'(ev_pop);
        if (ev_service) in_service_o <= 1'b1;
        if (ev_cpu && !in_service_o && req_excl_i) needs_excl_o <= 1'b1;
        if (push_def && req_excl_i) def_excl_o <= 1'b1;
        if (ev_snoop && snp_inval) pend_inval_o <= 1'b1;
        if (ev_promote) begin
          act_sel      <= ~act_sel;
          needs_excl_o <= def_excl_o;
          pend_inval_o <= 1'b0;
          def_excl_o   <= 1'b0;
          seq_o        <= def_head.seq;
          ready_time_o <= later_time(now_i, def_head.stamp);
        end
        if (ev_dealloc) begin
          valid_o      <= 1'b0;
          in_service_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/miss_track_entry_chk.sv
module miss_track_entry_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd_i,
  input logic          valid_o,
  input logic          in_service_o,
  input logic          needs_excl_o,
  input logic          pend_inval_o,
  input logic          def_excl_o,
  input logic [CW-1:0] ntargets_o,
  input logic          act_empty_o,
  input logic          act_full_o,
  input logic          def_empty_o,
  input logic          inhibit_o,
  input logic          promoted_o,
  input logic          overflow_o
);
  AST_ALLOC_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1) |=> (ntargets_o == CW'(1)) && !in_service_o && !pend_inval_o); // R1
  AST_SNOOP_AFTER_INVAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd3 && pend_inval_o) |=> $stable(ntargets_o) && !inhibit_o); // R5
  AST_INHIBIT_NEEDS_OWNERSHIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit_o) |-> $past(needs_excl_o) && $past(in_service_o)); // R6
  AST_PROMOTE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    promoted_o |-> !pend_inval_o && !def_excl_o && !act_empty_o && def_empty_o); // R8
  AST_DEALLOC_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> act_empty_o && def_empty_o && (ntargets_o == '0)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> $stable(ntargets_o)); // R11
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_full_o && act_empty_o)); // R11
  AST_CLOSED_SLOT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && cmd_i != 3'd1) |=> !valid_o && (ntargets_o == '0)); // R12
endmodule

bind miss_track_entry miss_track_entry_chk #(.CW($clog2(2*DEPTH+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .valid_o(valid_o),
  .in_service_o(in_service_o), .needs_excl_o(needs_excl_o),
  .pend_inval_o(pend_inval_o), .def_excl_o(def_excl_o), .ntargets_o(ntargets_o),
  .act_empty_o(act_empty_o), .act_full_o(act_full_o), .def_empty_o(def_empty_o),
  .inhibit_o(inhibit_o), .promoted_o(promoted_o), .overflow_o(overflow_o)
);

// File: tb/miss_track_entry_bench.sv
module miss_track_entry_bench;
  import mte_pkg::*;
  localparam int D = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [SIZE_W-1:0] req_size_i = '0;
  logic req_uncache_i = 1'b0, req_excl_i = 1'b0;
  logic [TAG_W-1:0] req_tag_i = '0;
  logic [TIME_W-1:0] req_stamp_i = '0, now_i = '0;
  logic [ORD_W-1:0] req_seq_i = '0;
  logic valid_o, in_service_o, uncache_o, needs_excl_o, pend_inval_o, def_excl_o;
  logic [ADDR_W-1:0] line_addr_o;
  logic [SIZE_W-1:0] line_size_o;
  logic [TIME_W-1:0] ready_time_o, head_stamp_o;
  logic [ORD_W-1:0] seq_o, head_seq_o;
  logic [3:0] ntargets_o;
  logic act_empty_o, act_full_o, def_empty_o, def_full_o, head_cpu_o;
  logic [TAG_W-1:0] head_tag_o;
  logic inhibit_o, promoted_o, overflow_o;

  always #5 clk = ~clk;

  miss_track_entry #(.DEPTH(D)) u_miss_track_entry (.*);

  typedef struct { int tag; int stamp; int seq; bit cpu; } bt_t;
  bt_t qa[$], qd[$];
  bit m_valid, m_svc, m_unc, m_nx, m_pi, m_dnx, m_inh, m_prom, m_ovf;
  longint m_addr, m_size, m_ready, m_seq, m_cnt;
  int checks = 0, errors = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint pick_later(longint t, longint s);
    if (s > t) return s;
    return t;
  endfunction

  task automatic model(int c, bit x, int tag, int st, int sq, longint now);
    bt_t t = '{tag: tag, stamp: st, seq: sq, cpu: 1'b1};
    bit dfr, rec;
    m_inh = 0; m_prom = 0; m_ovf = 0;
    if (c == 1) begin
      qa.delete(); qd.delete(); qa.push_back(t);
      m_valid = 1; m_svc = 0; m_addr = req_addr_i; m_size = req_size_i;
      m_unc = req_uncache_i; m_ready = st; m_seq = sq; m_nx = x;
      m_pi = 0; m_dnx = 0; m_cnt = 1;
    end else if (m_valid) begin
      case (c)
        2: begin
          dfr = m_svc && ((qd.size() > 0) || m_pi || (x && !m_nx));
          if (dfr) begin
            if (x) m_dnx = 1;
            if (qd.size() < D) begin qd.push_back(t); m_cnt++; end else m_ovf = 1;
          end else begin
            if (!m_svc && x) m_nx = 1;
            if (qa.size() < D) begin qa.push_back(t); m_cnt++; end else m_ovf = 1;
          end
        end
        3: if (m_svc && !m_pi) begin
          rec = 0;
          if (m_nx) begin m_inh = 1; rec = 1; end
          else if (x) begin m_pi = 1; rec = 1; end
          t.cpu = 1'b0;
          if (rec) begin
            if (qa.size() < D) begin qa.push_back(t); m_cnt++; end else m_ovf = 1;
          end
        end
        4: m_svc = 1;
        5: if (qa.size() > 0) begin void'(qa.pop_front()); m_cnt--; end
        6: if (qd.size() > 0 && qa.size() == 0) begin
          qa = qd; qd.delete();
          m_nx = m_dnx; m_pi = 0; m_dnx = 0; m_prom = 1;
          m_seq = qa[0].seq; m_ready = pick_later(now, qa[0].stamp);
        end
        7: if (qa.size() == 0 && qd.size() == 0) begin m_valid = 0; m_svc = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk("R12", "valid", valid_o, m_valid);
    chk("R10", "in_service", in_service_o, m_svc);
    chk("R10", "ntargets", ntargets_o, m_cnt);
    chk("R2", "needs_excl", needs_excl_o, m_nx);
    chk("R7", "pend_inval", pend_inval_o, m_pi);
    chk("R4", "def_excl", def_excl_o, m_dnx);
    chk("R6", "inhibit", inhibit_o, m_inh);
    chk("R8", "promoted", promoted_o, m_prom);
    chk("R11", "overflow", overflow_o, m_ovf);
    chk("R3", "act_empty", act_empty_o, qa.size() == 0);
    chk("R3", "def_empty", def_empty_o, qd.size() == 0);
    chk("R11", "act_full", act_full_o, qa.size() == D);
    chk("R11", "def_full", def_full_o, qd.size() == D);
    if (m_valid) begin
      chk("R1", "addr", line_addr_o, m_addr);
      chk("R1", "size", line_size_o, m_size);
      chk("R1", "uncache", uncache_o, m_unc);
      chk("R9", "ready_time", ready_time_o, m_ready);
      chk("R9", "seq", seq_o, m_seq);
    end
    if (qa.size() > 0) begin
      chk("R3", "head_tag", head_tag_o, qa[0].tag);
      chk("R3", "head_stamp", head_stamp_o, qa[0].stamp);
      chk("R3", "head_seq", head_seq_o, qa[0].seq);
      chk("R6", "head_cpu", head_cpu_o, qa[0].cpu);
    end
  endtask

  longint tnow = 0;

  task automatic step(int c, bit x, int st);
    int tg = int'($urandom_range(0, 255));
    int sq = int'($urandom_range(0, 255));
    tnow++;
    cmd_i = 3'(c); req_excl_i = x; req_tag_i = 8'(tg); req_seq_i = 8'(sq);
    req_stamp_i = 16'(st); now_i = 16'(tnow);
    req_addr_i = $urandom; req_size_i = 7'($urandom); req_uncache_i = 1'($urandom);
    model(c, x, tg, st, sq, tnow);
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int seed_discard;
    seed_discard = $urandom(20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "reset valid", valid_o, 0);
    chk("R12", "reset count", ntargets_o, 0);
    chk("R12", "reset act_empty", act_empty_o, 1);
    rst_n = 1'b1;
    // R12: commands to a closed slot
    step(2, 1, 5); step(4, 0, 5); step(6, 0, 5);
    // R1 R2: open shared, add exclusive before issue
    step(1, 0, 100); step(2, 1, 7); step(4, 0, 0);
    // R6: snoop while awaiting exclusive
    step(3, 0, 9); step(3, 1, 9);
    // R3 R11: fill active, then overflow
    step(2, 0, 1); step(2, 0, 2); step(2, 0, 3);
    // R5 R7 R3 R4: shared fetch issued then exclusive request deferred
    step(1, 0, 50); step(4, 0, 0); step(2, 1, 40); step(2, 0, 41);
    step(3, 1, 0); step(3, 1, 0); step(3, 0, 0);
    for (int i = 0; i < 4; i++) step(2, i[0], 42 + i);
    step(6, 0, 0);                       // R8: blocked, active not empty
    for (int i = 0; i < 3; i++) step(5, 0, 0);
    step(5, 0, 0);                       // R10: pop of empty
    step(7, 0, 0);                       // R10: dealloc refused
    step(6, 0, 0);                       // R8 R9: promote
    for (int i = 0; i < 5; i++) step(5, 0, 0);
    step(7, 0, 0);
    // random phase
    for (int n = 0; n < 20000; n++) begin
      int r = int'($urandom_range(0, 15));
      int c;
      if (r == 0) c = m_valid ? 2 : 1;
      else if (r <= 4) c = 2;
      else if (r <= 6) c = 3;
      else if (r == 7) c = 4;
      else if (r <= 10) c = 5;
      else if (r <= 12) c = 6;
      else if (r == 13) c = 7;
      else c = m_valid ? 0 : 1;
      step(c, 1'($urandom), int'($urandom_range(0, 65535)));
    end
    summary();
  end
endmodule